// File: doc/BRIEF.md
# Transmit Interrupt Status Generator

This block turns the status flags of an audio transmit FIFO into raw interrupt bits and drives a single level-sensitive interrupt line. Two raw bits follow FIFO conditions directly: a service request while the FIFO is at or below half full, and a completion indication while the FIFO is empty and the serializer is idle. The third bit records a transmit underrun. It is sticky, so it stays set after the FIFO refills and is removed only by software, which writes a clear command with the underrun-clear bit set.

Software supplies an enable mask. The interrupt line is high whenever a raw bit and its matching enable bit are both set. The complete raw vector is brought out so that a bus decoder outside this block can return it on a read. The four upper positions of that vector are kept for receive-side causes and always read as zero.

All state updates on the rising clock edge. Each output shows the flags, the event, the clear command and the mask write that were sampled at the previous edge. The block therefore re-evaluates itself on every cycle, which covers every register write and every drain request from the codec.

Top module: `txirq_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the sticky underrun flag and the enable mask are cleared. At the following sample point `raw_status` and `irq` are both zero, whatever the status inputs are.
- R2: Raw bit 1 (transmit request) equals the `st_half_empty` value sampled at the previous clock edge.
- R3: Raw bit 2 (transmit complete) is 1 exactly when, at the previous edge, `st_empty` was 1 and `st_busy` was 0.
- R4: Raw bit 0 (underrun) goes to 1 one clock after an edge that samples `st_underrun_evt` high. It stays 1 across later cycles while no clear command is given, even after the FIFO flags change.
- R5: A clear command (`clr_we` high) with `clr_wdata[0]`=1 returns raw bit 0 to 0 one clock later. A clear command with `clr_wdata[0]`=0 leaves bit 0 unchanged.
- R6: If an underrun event and an underrun clear are sampled at the same edge, the event wins and raw bit 0 is 1 afterwards.
- R7: `irq` is 1 exactly when the raw vector ANDed with the enable mask is nonzero, with the same one-clock latency as `raw_status`. A mask written by `ien_we`/`ien_wdata` at an edge already applies to the `irq` value produced at that edge.
- R8: Raw bits 6 down to 3 are reserved and always read 0. Setting the matching enable bits never raises `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| st_half_empty | input | 1 | FIFO at or below half full |
| st_empty | input | 1 | FIFO holds no samples |
| st_busy | input | 1 | Serializer is still shifting a frame |
| st_underrun_evt | input | 1 | One-cycle pulse: the FIFO ran dry while being drained |
| ien_we | input | 1 | Write strobe for the enable mask |
| ien_wdata | input | 7 | New enable mask, one bit per raw position |
| clr_we | input | 1 | Write strobe for the clear command |
| clr_wdata | input | 7 | Clear command; bit 0 clears the underrun flag |
| raw_status | output | 7 | Registered raw interrupt vector |
| irq | output | 1 | Registered level interrupt |

## Verification
The underrun event and the software clear of the same flag can occur in the same cycle. The bench provokes this by pulsing `st_underrun_evt` and writing a clear command with bit 0 set on one edge. It expects the flag, and the interrupt line when its enable bit is set, to be high afterwards. A second coincidence is a mask write on the same edge as a status change. The bench checks that the interrupt line reflects the new mask and the new status together, one clock later.

// File: rtl/txirq_pkg.sv
package txirq_pkg;
  parameter int RAW_W      = 7;
  parameter int BIT_UNDER  = 0;
  parameter int BIT_REQ    = 1;
  parameter int BIT_DONE   = 2;
  parameter int FIRST_RSVD = 3;
  parameter int CLR_UNDER  = 0;
endpackage

// File: rtl/txirq_sticky.sv
module txirq_sticky (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_next_o,
  output logic flag_q_o
);
  // a fresh event beats a simultaneous clear so it is never lost
  always_comb begin
    if (set_i)      flag_next_o = 1'b1;
    else if (clr_i) flag_next_o = 1'b0;
    else            flag_next_o = flag_q_o;
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q_o <= 1'b0;
    else     flag_q_o <= flag_next_o;
  end
endmodule

// File: rtl/txirq_raw_map.sv
module txirq_raw_map import txirq_pkg::*; (
  input  logic             under_i,
  input  logic             half_empty_i,
  input  logic             empty_i,
  input  logic             busy_i,
  output logic [RAW_W-1:0] raw_o
);
  assign raw_o[BIT_UNDER] = under_i;
  assign raw_o[BIT_REQ]   = half_empty_i;
  assign raw_o[BIT_DONE]  = empty_i & ~busy_i;

  // receive-side positions held at zero
  for (genvar g = FIRST_RSVD; g < RAW_W; g++) begin : g_rsvd
    assign raw_o[g] = 1'b0;
  end
endmodule

// File: rtl/txirq_mask_out.sv
module txirq_mask_out import txirq_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic [RAW_W-1:0] raw_i,
  input  logic             ien_we,
  input  logic [RAW_W-1:0] ien_wdata,
  output logic [RAW_W-1:0] raw_q_o,
  output logic             irq_q_o
);
  logic [RAW_W-1:0] ien_q;
  logic [RAW_W-1:0] ien_next;

  assign ien_next = ien_we ? ien_wdata : ien_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q   <= '0;
      raw_q_o <= '0;
      irq_q_o <= 1'b0;
    end else begin
      ien_q   <= ien_next;
      raw_q_o <= raw_i;
      irq_q_o <= |(raw_i & ien_next);
    end
  end
endmodule

// File: rtl/txirq_gen.sv
module txirq_gen import txirq_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic             st_half_empty,
  input  logic             st_empty,
  input  logic             st_busy,
  input  logic             st_underrun_evt,
  input  logic             ien_we,
  input  logic [RAW_W-1:0] ien_wdata,
  input  logic             clr_we,
  input  logic [RAW_W-1:0] clr_wdata,
  output logic [RAW_W-1:0] raw_status,
  output logic             irq
);
  logic             under_next;
  logic             under_q;
  logic [RAW_W-1:0] raw_comb;

  txirq_sticky u_under (
    .clk         (clk),
    .rst         (rst),
    .set_i       (st_underrun_evt),
    .clr_i       (clr_we & clr_wdata[CLR_UNDER]),
    .flag_next_o (under_next),
    .flag_q_o    (under_q)
  );

  txirq_raw_map u_map (
    .under_i      (under_next),
    .half_empty_i (st_half_empty),
    .empty_i      (st_empty),
    .busy_i       (st_busy),
    .raw_o        (raw_comb)
  );

  txirq_mask_out u_out (
    .clk       (clk),
    .rst       (rst),
    .raw_i     (raw_comb),
    .ien_we    (ien_we),
    .ien_wdata (ien_wdata),
    .raw_q_o   (raw_status),
    .irq_q_o   (irq)
  );
endmodule

// File: rtl/txirq_gen_chk.sv
module txirq_gen_chk import txirq_pkg::*; (
  input logic             clk,
  input logic             rst,
  input logic             st_half_empty,
  input logic             st_empty,
  input logic             st_busy,
  input logic             st_underrun_evt,
  input logic             clr_we,
  input logic [RAW_W-1:0] clr_wdata,
  input logic [RAW_W-1:0] raw_status,
  input logic             irq
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (raw_status == '0 && !irq));

  a_r2_req_follows: assert property (@(posedge clk) disable iff (rst)
    st_half_empty |=> raw_status[BIT_REQ]);

  a_r3_done_set: assert property (@(posedge clk) disable iff (rst)
    (st_empty && !st_busy) |=> raw_status[BIT_DONE]);

  a_r3_done_clr: assert property (@(posedge clk) disable iff (rst)
    (!st_empty || st_busy) |=> !raw_status[BIT_DONE]);

  a_r4_sticky_hold: assert property (@(posedge clk) disable iff (rst)
    (raw_status[BIT_UNDER] && !(clr_we && clr_wdata[CLR_UNDER])) |=> raw_status[BIT_UNDER]);

  a_r5_clear_works: assert property (@(posedge clk) disable iff (rst)
    (clr_we && clr_wdata[CLR_UNDER] && !st_underrun_evt) |=> !raw_status[BIT_UNDER]);

  a_r6_event_wins: assert property (@(posedge clk) disable iff (rst)
    st_underrun_evt |=> raw_status[BIT_UNDER]);

  a_r7_irq_needs_raw: assert property (@(posedge clk) disable iff (rst)
    irq |-> (raw_status != '0));

  a_r8_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
    raw_status[RAW_W-1:FIRST_RSVD] == '0);
endmodule

bind txirq_gen txirq_gen_chk u_chk (
  .clk             (clk),
  .rst             (rst),
  .st_half_empty   (st_half_empty),
  .st_empty        (st_empty),
  .st_busy         (st_busy),
  .st_underrun_evt (st_underrun_evt),
  .clr_we          (clr_we),
  .clr_wdata       (clr_wdata),
  .raw_status      (raw_status),
  .irq             (irq)
);

// File: tb/txirq_gen_tb_top.sv
`timescale 1ns/1ps
module txirq_gen_tb_top;
  localparam int W = 7;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         he = 1'b0, fe = 1'b0, busy = 1'b0, evt = 1'b0;
  logic         ien_we = 1'b0, clr_we = 1'b0;
  logic [W-1:0] ien_wdata = '0, clr_wdata = '0;
  logic [W-1:0] raw_status;
  logic         irq;

  always #5 clk = ~clk;

  txirq_gen dut_i (
    .clk(clk), .rst(rst),
    .st_half_empty(he), .st_empty(fe), .st_busy(busy), .st_underrun_evt(evt),
    .ien_we(ien_we), .ien_wdata(ien_wdata),
    .clr_we(clr_we), .clr_wdata(clr_wdata),
    .raw_status(raw_status), .irq(irq)
  );

  typedef struct {
    logic [W-1:0] raw;
    logic         irq;
    string        tag;
  } exp_t;

  exp_t         sb_q[$];
  int           checks = 0;
  int           fails  = 0;
  logic         m_ur   = 1'b0;
  logic [W-1:0] m_ien  = '0;
  bit           done   = 1'b0;

  // monitor: compare just after each rising edge
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (raw_status !== e.raw || irq !== e.irq) begin
        fails++;
        $display("FAIL %s raw=%b irq=%b expected raw=%b irq=%b",
                 e.tag, raw_status, irq, e.raw, e.irq);
      end
    end
  end

  task automatic step(input logic h, input logic f, input logic b, input logic ev,
                      input logic iw, input logic [W-1:0] id,
                      input logic cw, input logic [W-1:0] cd, input string tag);
    exp_t e;
    logic [W-1:0] r;
    @(negedge clk);
    rst = 1'b0; he = h; fe = f; busy = b; evt = ev;
    ien_we = iw; ien_wdata = id; clr_we = cw; clr_wdata = cd;
    if (ev) m_ur = 1'b1;
    else if (cw && cd[0]) m_ur = 1'b0;
    if (iw) m_ien = id;
    r = '0;
    r[0] = m_ur;
    r[1] = h;
    r[2] = f & ~b;
    e.raw = r;
    e.irq = |(r & m_ien);
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic do_reset(input string tag);
    exp_t e;
    @(negedge clk);
    rst = 1'b1; he = 1'b1; fe = 1'b1; busy = 1'b0; evt = 1'b1;
    ien_we = 1'b1; ien_wdata = '1; clr_we = 1'b0; clr_wdata = '0;
    m_ur = 1'b0; m_ien = '0;
    e.raw = '0; e.irq = 1'b0; e.tag = tag;
    sb_q.push_back(e);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset("R1");
    do_reset("R1");
    // R2 / R3 flag mapping
    step(1,1,0,0, 0,'0, 0,'0, "R2");
    step(0,1,0,0, 0,'0, 0,'0, "R2");
    step(1,1,1,0, 0,'0, 0,'0, "R3");
    step(0,0,0,0, 0,'0, 0,'0, "R3");
    step(0,1,0,0, 0,'0, 0,'0, "R3");
    // R4 sticky underrun
    step(0,1,0,1, 0,'0, 0,'0, "R4");
    step(1,0,1,0, 0,'0, 0,'0, "R4");
    step(0,0,1,0, 0,'0, 0,'0, "R4");
    // R5 clear command
    step(0,0,1,0, 0,'0, 1,7'b1111110, "R5");
    step(0,0,1,0, 0,'0, 1,7'b0000001, "R5");
    step(0,0,1,0, 0,'0, 0,'0, "R5");
    // R6 event and clear together, with mask written the same edge
    step(0,0,1,1, 1,7'b0000001, 1,7'b0000001, "R6");
    step(0,0,1,0, 0,'0, 0,'0, "R6");
    step(0,0,1,0, 0,'0, 1,7'b0000001, "R7");
    // R7 mask gating
    step(1,0,1,0, 0,'0, 0,'0, "R7");
    step(1,0,1,0, 1,7'b0000010, 0,'0, "R7");
    step(0,0,1,0, 0,'0, 0,'0, "R7");
    step(0,1,0,0, 1,7'b0000100, 0,'0, "R7");
    step(0,1,1,0, 0,'0, 0,'0, "R7");
    // R8 reserved enables do nothing
    step(0,0,1,0, 1,7'b1111000, 0,'0, "R8");
    step(0,0,1,0, 0,'0, 0,'0, "R8");
    step(1,1,0,1, 1,7'b0000111, 0,'0, "R7");
    // R1 reset in mid-run
    do_reset("R1");
    step(0,0,1,0, 0,'0, 0,'0, "R1");
    step(1,0,1,0, 0,'0, 0,'0, "R1");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule